// File: doc/BRIEF.md
# I2C Byte FIFO and Transfer Flow Controller

This block sits between a host register port and an I2C byte engine and decides how bytes move between them. A single 16-entry byte FIFO serves both directions. In transmit mode the host fills it and the engine drains it. In receive mode the engine fills it and the host drains it. A transfer-size counter tracks how many bytes are still to be received. The block also tells the engine, for each byte, whether to acknowledge it, whether to stretch the clock, and when to end the bus with a STOP.

A host write to the address input starts a transfer, and the mode comes from the control word. A hold bit keeps the bus claimed after a transfer so that the next address write produces a repeated START. While hold is set, the block stretches the clock whenever the FIFO cannot keep pace. Wave generation, arbitration and interrupt registers live elsewhere. This block only raises one-cycle event pulses for them.

Top module: `i2c_xfer_flow`

## Requirements
- R1: In transmit mode (control bit 0 = 0), `size_q` reports the number of bytes held in the FIFO, from 0 to 16. A host push while 16 bytes are held is dropped, and `ev_tx_ovf` pulses in the cycle after that push.
- R2: In transmit mode, while a transfer is running, `eng_tx_valid` is high whenever the FIFO is non-empty, and `eng_tx_data` shows the oldest byte. Each `eng_byte_done` removes that byte. The removal that empties the FIFO raises `ev_done` in the following cycle.
- R3: `size_we` loads the receive counter. In receive mode (control bit 0 = 1), `size_q` reads the counter, which drops by one for every received byte the FIFO accepts. In transmit mode a `size_we` write leaves `size_q` unchanged.
- R4: `eng_ack` is high only when all of these hold: a receive transfer is running, acknowledge-enable (control bit 3) is set, and more than one byte remains. With exactly one byte left, the byte is answered with NACK (`eng_ack` low).
- R5: When a running receive transfer reaches a remaining count of zero, the transfer ends at the next clock edge and `ev_done` pulses for one cycle.
- R6: When the bus is claimed but idle (receive finished, transmit FIFO empty, or a transmit started with nothing queued) and hold (control bit 4) is clear, `ev_stop` pulses one cycle later and `bus_active` drops. With hold set, no STOP is issued and `bus_active` stays high. Clearing hold later produces the STOP one cycle after the control write.
- R7: `eng_stretch` is high when hold is set and a transfer is running with either (a) a full receive FIFO and a non-zero remaining count, or (b) an empty transmit FIFO. It is never high while hold is clear.
- R8: `ev_data` pulses in the cycle after a received byte brings the FIFO level to 14, which is the depth minus 2. `rx_ready` is high in receive mode whenever the FIFO holds data.
- R9: A received byte arriving while the FIFO is full is dropped. `ev_rx_ovf` pulses and the remaining count stays the same. A host pop from an empty receive FIFO pulses `ev_rx_unf`.
- R10: A control write with bit 6 set reads back bit 6 as 1 for one cycle. At the next edge the FIFO empties and bit 6 clears by itself.
- R11: An address write starts a transfer. In the next cycle `eng_start` pulses, `eng_addr` holds the 10-bit address and `bus_active` is high. `eng_addr7` follows control bit 2 (1 = 7-bit addressing), and `eng_rx` follows control bit 0.
- R12: After reset, the control word and `size_q` are zero, `bus_active`, `rx_ready` and `eng_tx_valid` are low, and no event pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word: bit0 receive, bit2 7-bit address, bit3 ack enable, bit4 hold, bit6 FIFO flush |
| ctl_q | output | 8 | Control word readback |
| size_we | input | 1 | Receive counter load strobe |
| size_wdata | input | 8 | Receive counter load value (at most 255) |
| size_q | output | 8 | Remaining count (receive) or FIFO level (transmit) |
| addr_we | input | 1 | Address write; starts a transfer |
| addr_wdata | input | 10 | Target address |
| host_push | input | 1 | Host pushes a transmit byte |
| host_wdata | input | 8 | Transmit byte from host |
| host_pop | input | 1 | Host pops a received byte |
| host_rdata | output | 8 | Oldest FIFO byte for the host |
| rx_ready | output | 1 | Received data waiting |
| bus_active | output | 1 | Bus claimed by this controller |
| eng_start | output | 1 | One-cycle pulse: begin START/repeated START |
| eng_addr | output | 10 | Address for the engine |
| eng_addr7 | output | 1 | 7-bit addressing selected |
| eng_rx | output | 1 | Current direction is receive |
| eng_byte_done | input | 1 | Engine finished one byte |
| eng_rx_data | input | 8 | Byte received by the engine |
| eng_tx_data | output | 8 | Next byte to send |
| eng_tx_valid | output | 1 | A transmit byte is available |
| eng_ack | output | 1 | Acknowledge the byte in flight |
| eng_stretch | output | 1 | Hold SCL low |
| ev_done | output | 1 | Transfer complete pulse |
| ev_stop | output | 1 | Issue STOP pulse |
| ev_data | output | 1 | Receive level reached depth minus 2 |
| ev_tx_ovf | output | 1 | Transmit overflow pulse |
| ev_rx_ovf | output | 1 | Receive overflow pulse |
| ev_rx_unf | output | 1 | Receive underflow pulse |

## Verification
Every strobe is taken at one clock edge. The state it changes, and the event pulses it raises, can be seen in the cycle right after that edge, so the bench drives on the falling edge and reads one falling edge later. Some results take one extra edge: the end of a receive (`ev_done` after the count reaches zero), every `ev_stop`, and the FIFO flush after a bit-6 write. For these the bench waits exactly one more cycle before reading. `eng_ack` and `eng_stretch` are combinational on the current state, so they are read before the byte strobe they apply to. Pulse totals across a whole transfer are gathered by a falling-edge monitor.

// File: rtl/i2c_flow_pkg.sv
package i2c_flow_pkg;

    localparam int FLOW_DEPTH  = 16;
    localparam int FLOW_DATA_W = 8;
    localparam int FLOW_SIZE_W = 8;
    localparam int FLOW_ADDR_W = 10;
    localparam int FLOW_GAP    = 2;

    // Control word layout; the host decodes these positions.
    typedef struct packed {
        logic rsv7;
        logic flush;
        logic rsv5;
        logic hold;
        logic ack_en;
        logic addr7;
        logic rsv1;
        logic rx;
    } flow_ctl_t;

    localparam logic [7:0] FLOW_CTL_MASK = 8'b0101_1101;

    typedef struct packed {
        logic push;
        logic pop;
        logic flush;
    } fifo_op_t;

    function automatic logic at_threshold(input int unsigned level_after,
                                          input int unsigned depth);
        return level_after == depth - FLOW_GAP;
    endfunction

endpackage

// File: rtl/i2c_flow_fifo.sv
module i2c_flow_fifo
    import i2c_flow_pkg::*;
#(
    parameter int WIDTH = FLOW_DATA_W,
    parameter int DEPTH = FLOW_DEPTH,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  fifo_op_t         op,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic [LW-1:0]    level,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = op.push && !full && !op.flush;
    assign do_pop  = op.pop && !empty && !op.flush;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || op.flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

endmodule

// File: rtl/i2c_flow_count.sv
module i2c_flow_count
    import i2c_flow_pkg::*;
#(
    parameter int W = FLOW_SIZE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] remain,
    output logic         zero,
    output logic         last
);

    assign zero = (remain == '0);
    assign last = (remain == W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (dec && !zero)
            remain <= remain - 1'b1;
    end

endmodule

// File: rtl/i2c_flow_policy.sv
module i2c_flow_policy (
    input  logic busy,
    input  logic rx,
    input  logic ack_en,
    input  logic hold,
    input  logic full,
    input  logic empty,
    input  logic rem_zero,
    input  logic rem_last,
    output logic ack,
    output logic stretch,
    output logic tx_valid
);

    logic rx_run, tx_run;

    assign rx_run   = busy && rx;
    assign tx_run   = busy && !rx;
    assign ack      = rx_run && ack_en && !rem_zero && !rem_last;
    assign stretch  = hold && ((rx_run && full && !rem_zero) || (tx_run && empty));
    assign tx_valid = tx_run && !empty;

endmodule

// File: rtl/i2c_xfer_flow.sv
module i2c_xfer_flow
    import i2c_flow_pkg::*;
#(
    parameter int DATA_W = FLOW_DATA_W,
    parameter int DEPTH  = FLOW_DEPTH,
    parameter int SIZE_W = FLOW_SIZE_W,
    parameter int ADDR_W = FLOW_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_q,
    input  logic              size_we,
    input  logic [SIZE_W-1:0] size_wdata,
    output logic [SIZE_W-1:0] size_q,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              host_push,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_pop,
    output logic [DATA_W-1:0] host_rdata,
    output logic              rx_ready,
    output logic              bus_active,
    output logic              eng_start,
    output logic [ADDR_W-1:0] eng_addr,
    output logic              eng_addr7,
    output logic              eng_rx,
    input  logic              eng_byte_done,
    input  logic [DATA_W-1:0] eng_rx_data,
    output logic [DATA_W-1:0] eng_tx_data,
    output logic              eng_tx_valid,
    output logic              eng_ack,
    output logic              eng_stretch,
    output logic              ev_done,
    output logic              ev_stop,
    output logic              ev_data,
    output logic              ev_tx_ovf,
    output logic              ev_rx_ovf,
    output logic              ev_rx_unf
);

    localparam int LW = $clog2(DEPTH + 1);

    flow_ctl_t         ctl;
    fifo_op_t          fop;
    logic [DATA_W-1:0] fifo_rdata, fifo_wdata;
    logic [LW-1:0]     fifo_level;
    logic              fifo_full, fifo_empty;
    logic [SIZE_W-1:0] remain;
    logic              rem_zero, rem_last;
    logic              busy;
    logic              eng_take, rx_push, tx_push, rx_pop, tx_pop;
    logic              rx_finish, tx_drain, stop_cond, level_hit;

    // Control word with self-clearing flush bit
    always_ff @(posedge clk) begin
        if (rst)
            ctl <= '0;
        else if (ctl_we)
            ctl <= flow_ctl_t'(ctl_wdata & FLOW_CTL_MASK);
        else if (ctl.flush)
            ctl.flush <= 1'b0;
    end

    // FIFO source and sink selection per direction
    assign eng_take = busy && ctl.rx && eng_byte_done && !rem_zero;
    assign rx_push  = eng_take && !fifo_full;
    assign tx_push  = !ctl.rx && host_push && !fifo_full;
    assign rx_pop   = ctl.rx && host_pop && !fifo_empty;
    assign tx_pop   = busy && !ctl.rx && eng_byte_done && !fifo_empty;

    assign fop.push   = rx_push || tx_push;
    assign fop.pop    = rx_pop || tx_pop;
    assign fop.flush  = ctl.flush;
    assign fifo_wdata = ctl.rx ? eng_rx_data : host_wdata;

    i2c_flow_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .op    (fop),
        .wdata (fifo_wdata),
        .rdata (fifo_rdata),
        .level (fifo_level),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    i2c_flow_count #(.W(SIZE_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (size_we),
        .load_val (size_wdata),
        .dec      (rx_push),
        .remain   (remain),
        .zero     (rem_zero),
        .last     (rem_last)
    );

    i2c_flow_policy u_policy (
        .busy     (busy),
        .rx       (ctl.rx),
        .ack_en   (ctl.ack_en),
        .hold     (ctl.hold),
        .full     (fifo_full),
        .empty    (fifo_empty),
        .rem_zero (rem_zero),
        .rem_last (rem_last),
        .ack      (eng_ack),
        .stretch  (eng_stretch),
        .tx_valid (eng_tx_valid)
    );

    // Transfer sequencing
    assign rx_finish = busy && ctl.rx && rem_zero;
    assign tx_drain  = tx_pop && !tx_push && (fifo_level == LW'(1));
    assign stop_cond = bus_active && !ctl.hold && (!busy || (!ctl.rx && fifo_empty));
    assign level_hit = at_threshold(32'(fifo_level) + 1, DEPTH);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            bus_active <= 1'b0;
            eng_start  <= 1'b0;
            eng_addr   <= '0;
            ev_done    <= 1'b0;
            ev_stop    <= 1'b0;
            ev_data    <= 1'b0;
            ev_tx_ovf  <= 1'b0;
            ev_rx_ovf  <= 1'b0;
            ev_rx_unf  <= 1'b0;
        end else begin
            eng_start <= 1'b0;
            ev_done   <= 1'b0;
            ev_stop   <= 1'b0;
            if (addr_we) begin
                busy       <= 1'b1;
                bus_active <= 1'b1;
                eng_addr   <= addr_wdata;
                eng_start  <= 1'b1;
            end else if (stop_cond) begin
                busy       <= 1'b0;
                bus_active <= 1'b0;
                ev_stop    <= 1'b1;
            end else if (rx_finish) begin
                busy    <= 1'b0;
                ev_done <= 1'b1;
            end
            if (tx_drain) ev_done <= 1'b1;
            ev_data   <= rx_push && !rx_pop && !ctl.flush && level_hit;
            ev_tx_ovf <= !ctl.rx && host_push && fifo_full;
            ev_rx_ovf <= eng_take && fifo_full;
            ev_rx_unf <= ctl.rx && host_pop && fifo_empty;
        end
    end

    assign ctl_q       = ctl;
    assign size_q      = ctl.rx ? remain : SIZE_W'(fifo_level);
    assign host_rdata  = fifo_rdata;
    assign eng_tx_data = fifo_rdata;
    assign rx_ready    = ctl.rx && !fifo_empty;
    assign eng_addr7   = ctl.addr7;
    assign eng_rx      = ctl.rx;

endmodule

// File: rtl/i2c_xfer_flow_chk.sv
module i2c_xfer_flow_chk #(
    parameter int DEPTH  = 16,
    parameter int SIZE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_we,
    input logic              size_we,
    input logic [7:0]        ctl_q,
    input logic [SIZE_W-1:0] size_q,
    input logic              eng_ack,
    input logic              eng_stretch,
    input logic              eng_start,
    input logic              bus_active,
    input logic              ev_stop,
    input logic              ev_tx_ovf,
    input logic              ev_rx_ovf
);

    p_tx_level_r1: assert property (@(posedge clk) disable iff (rst)
        !ctl_q[0] |-> size_q <= SIZE_W'(DEPTH));

    p_tx_ovf_full_r1: assert property (@(posedge clk) disable iff (rst)
        ev_tx_ovf |-> $past(size_q) == SIZE_W'(DEPTH));

    p_nack_last_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl_q[0] && size_q == SIZE_W'(1)) |-> !eng_ack);

    p_stop_unheld_r6: assert property (@(posedge clk) disable iff (rst)
        ev_stop |-> !$past(ctl_q[4]));

    p_no_stretch_unheld_r7: assert property (@(posedge clk) disable iff (rst)
        !ctl_q[4] |-> !eng_stretch);

    p_rx_ovf_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (ev_rx_ovf && !$past(size_we) && !$past(ctl_we)) |-> size_q == $past(size_q));

    p_flush_selfclear_r10: assert property (@(posedge clk) disable iff (rst)
        (ctl_q[6] && !ctl_we) |=> !ctl_q[6]);

    p_flush_empties_r10: assert property (@(posedge clk) disable iff (rst)
        (ctl_q[6] && !ctl_we && !ctl_q[0]) |=> size_q == '0);

    p_start_active_r11: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> bus_active);

endmodule

bind i2c_xfer_flow i2c_xfer_flow_chk #(.DEPTH(DEPTH), .SIZE_W(SIZE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_we      (ctl_we),
    .size_we     (size_we),
    .ctl_q       (ctl_q),
    .size_q      (size_q),
    .eng_ack     (eng_ack),
    .eng_stretch (eng_stretch),
    .eng_start   (eng_start),
    .bus_active  (bus_active),
    .ev_stop     (ev_stop),
    .ev_tx_ovf   (ev_tx_ovf),
    .ev_rx_ovf   (ev_rx_ovf)
);

// File: tb/i2c_xfer_flow_test.sv
module i2c_xfer_flow_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0, size_we = 1'b0, addr_we = 1'b0;
    logic [7:0] ctl_wdata = '0, size_wdata = '0;
    logic [9:0] addr_wdata = '0;
    logic       host_push = 1'b0, host_pop = 1'b0, eng_byte_done = 1'b0;
    logic [7:0] host_wdata = '0, eng_rx_data = '0;
    logic [7:0] ctl_q, size_q, host_rdata, eng_tx_data;
    logic [9:0] eng_addr;
    logic rx_ready, bus_active, eng_start, eng_addr7, eng_rx, eng_tx_valid;
    logic eng_ack, eng_stretch, ev_done, ev_stop, ev_data, ev_tx_ovf, ev_rx_ovf, ev_rx_unf;

    int tests = 0, fails = 0;
    int n_done = 0, n_stop = 0;

    always #5 clk = ~clk;

    i2c_xfer_flow uut (
        .clk(clk), .rst(rst),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
        .size_we(size_we), .size_wdata(size_wdata), .size_q(size_q),
        .addr_we(addr_we), .addr_wdata(addr_wdata),
        .host_push(host_push), .host_wdata(host_wdata),
        .host_pop(host_pop), .host_rdata(host_rdata),
        .rx_ready(rx_ready), .bus_active(bus_active),
        .eng_start(eng_start), .eng_addr(eng_addr), .eng_addr7(eng_addr7), .eng_rx(eng_rx),
        .eng_byte_done(eng_byte_done), .eng_rx_data(eng_rx_data),
        .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid),
        .eng_ack(eng_ack), .eng_stretch(eng_stretch),
        .ev_done(ev_done), .ev_stop(ev_stop), .ev_data(ev_data),
        .ev_tx_ovf(ev_tx_ovf), .ev_rx_ovf(ev_rx_ovf), .ev_rx_unf(ev_rx_unf)
    );

    always @(negedge clk) begin
        if (!rst) begin
            n_done += int'(ev_done);
            n_stop += int'(ev_stop);
        end
    end

    typedef struct packed {
        logic [7:0] n;
        logic       ack_en;
        logic       hold;
        logic [7:0] acks;
        logic       stop;
    } rx_vec_t;

    localparam rx_vec_t RX_TAB [5] = '{
        '{8'd1, 1'b1, 1'b0, 8'd0, 1'b1},
        '{8'd3, 1'b1, 1'b0, 8'd2, 1'b1},
        '{8'd4, 1'b0, 1'b0, 8'd0, 1'b1},
        '{8'd5, 1'b1, 1'b1, 8'd4, 1'b0},
        '{8'd2, 1'b1, 1'b1, 8'd1, 1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_we = 1'b1; ctl_wdata = v; tick(); ctl_we = 1'b0;
    endtask

    task automatic wr_size(input logic [7:0] v);
        size_we = 1'b1; size_wdata = v; tick(); size_we = 1'b0;
    endtask

    task automatic wr_addr(input logic [9:0] a);
        addr_we = 1'b1; addr_wdata = a; tick(); addr_we = 1'b0;
    endtask

    task automatic push_b(input logic [7:0] d);
        host_push = 1'b1; host_wdata = d; tick(); host_push = 1'b0;
    endtask

    task automatic pop_b();
        host_pop = 1'b1; tick(); host_pop = 1'b0;
    endtask

    task automatic eng_b(input logic [7:0] d);
        eng_byte_done = 1'b1; eng_rx_data = d; tick(); eng_byte_done = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int acks, d0, s0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R12 reset state
        chk("R12 ctl_q", int'(ctl_q), 0);
        chk("R12 size_q", int'(size_q), 0);
        chk("R12 bus_active", int'(bus_active), 0);
        chk("R12 rx_ready/tx_valid", int'({rx_ready, eng_tx_valid}), 0);
        chk("R12 events", int'({ev_done, ev_stop, ev_data, ev_tx_ovf, ev_rx_ovf, ev_rx_unf}), 0);

        // Table of receive transfers: R4 ack pattern, R5 completion, R6 stop/hold
        for (int i = 0; i < 5; i++) begin
            rx_vec_t e = RX_TAB[i];
            acks = 0; d0 = n_done; s0 = n_stop;
            wr_ctl({3'b000, e.hold, e.ack_en, 2'b00, 1'b1});
            wr_size(e.n);
            wr_addr(10'h050 + 10'(i));
            for (int k = 0; k < int'(e.n); k++) begin
                acks += int'(eng_ack);
                eng_b(8'hA0 + 8'(k));
                chk("R8 rx_ready", int'(rx_ready), 1);
                chk("R3 rx data order", int'(host_rdata), 'hA0 + k);
                pop_b();
            end
            tick(); tick();
            chk("R4 ack count", acks, int'(e.acks));
            chk("R5 done count", n_done - d0, 1);
            chk("R6 stop count", n_stop - s0, int'(e.stop));
            chk("R6 bus_active", int'(bus_active), int'(!e.stop));
            if (e.hold) begin
                wr_ctl(8'h00);
                tick();
                chk("R6 stop after hold release", n_stop - s0, 1);
                chk("R6 bus released", int'(bus_active), 0);
            end
        end

        // R1/R2/R3/R11 transmit path
        wr_ctl(8'h00);
        push_b(8'h11); push_b(8'h22); push_b(8'h33);
        chk("R1 tx level", int'(size_q), 3);
        wr_size(8'd9);
        chk("R3 size write ignored in tx", int'(size_q), 3);
        wr_addr(10'h2A5);
        chk("R11 start pulse", int'(eng_start), 1);
        chk("R11 address", int'(eng_addr), 'h2A5);
        chk("R11 bus_active", int'(bus_active), 1);
        chk("R11 addr7/rx", int'({eng_addr7, eng_rx}), 0);
        chk("R2 tx valid", int'(eng_tx_valid), 1);
        chk("R2 first byte", int'(eng_tx_data), 'h11);
        eng_b(8'h00);
        chk("R2 second byte", int'(eng_tx_data), 'h22);
        eng_b(8'h00);
        chk("R2 third byte", int'(eng_tx_data), 'h33);
        chk("R2 no early done", int'(ev_done), 0);
        eng_b(8'h00);
        chk("R2 done on drain", int'(ev_done), 1);
        chk("R1 tx level empty", int'(size_q), 0);
        tick();
        chk("R6 stop after drain", int'(ev_stop), 1);
        chk("R6 bus released", int'(bus_active), 0);

        // R1 overflow, R10 flush
        for (int k = 0; k < 16; k++) push_b(8'(k));
        chk("R1 no overflow at 16", int'(ev_tx_ovf), 0);
        push_b(8'hEE);
        chk("R1 overflow pulse", int'(ev_tx_ovf), 1);
        chk("R1 level capped", int'(size_q), 16);
        wr_ctl(8'h40);
        chk("R10 flush bit set", int'(ctl_q[6]), 1);
        tick();
        chk("R10 flush bit cleared", int'(ctl_q[6]), 0);
        chk("R10 fifo emptied", int'(size_q), 0);

        // Receive with hold: R8 threshold, R7 stretch, R9 overflow/underflow
        wr_ctl(8'h19);
        wr_size(8'd20);
        wr_addr(10'h033);
        for (int k = 0; k < 16; k++) begin
            eng_b(8'h40 + 8'(k));
            if (k == 12) chk("R8 no event at 13", int'(ev_data), 0);
            if (k == 13) chk("R8 event at 14", int'(ev_data), 1);
        end
        chk("R3 remaining", int'(size_q), 4);
        chk("R7 stretch on full", int'(eng_stretch), 1);
        chk("R4 ack mid transfer", int'(eng_ack), 1);
        eng_b(8'hFF);
        chk("R9 rx overflow", int'(ev_rx_ovf), 1);
        chk("R9 count kept", int'(size_q), 4);
        chk("R9 oldest byte kept", int'(host_rdata), 'h40);
        pop_b();
        chk("R7 stretch released", int'(eng_stretch), 0);
        wr_ctl(8'h59);
        tick();
        chk("R8 rx_ready after flush", int'(rx_ready), 0);
        pop_b();
        chk("R9 rx underflow", int'(ev_rx_unf), 1);
        for (int k = 0; k < 4; k++) begin
            if (k == 3) chk("R4 nack last byte", int'(eng_ack), 0);
            eng_b(8'h60 + 8'(k));
        end
        chk("R5 no done before finish edge", int'(ev_done), 0);
        tick();
        chk("R5 done after count zero", int'(ev_done), 1);
        s0 = n_stop;
        tick(); tick();
        chk("R6 held no stop", n_stop - s0, 0);
        chk("R6 held bus", int'(bus_active), 1);
        wr_ctl(8'h01);
        tick();
        chk("R6 stop on release", int'(ev_stop), 1);

        // Transmit with hold: R7 stretch on empty, R11 addr7
        wr_ctl(8'h54);
        tick();
        push_b(8'h77);
        wr_addr(10'h3FF);
        chk("R11 addr7 follows ctl", int'(eng_addr7), 1);
        chk("R11 full address", int'(eng_addr), 'h3FF);
        eng_b(8'h00);
        chk("R2 done held", int'(ev_done), 1);
        chk("R7 stretch on empty tx", int'(eng_stretch), 1);
        s0 = n_stop;
        tick();
        chk("R6 held tx no stop", n_stop - s0, 0);
        push_b(8'h88);
        chk("R7 stretch off with data", int'(eng_stretch), 0);
        chk("R2 refilled byte", int'(eng_tx_data), 'h88);
        eng_b(8'h00);
        wr_ctl(8'h00);
        tick();
        chk("R6 stop after tx hold release", int'(ev_stop), 1);

        // R6 transmit started with nothing queued
        wr_addr(10'h012);
        tick();
        chk("R6 stop on empty start", int'(ev_stop), 1);
        chk("R6 bus idle", int'(bus_active), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule